// File: doc/BRIEF.md
# Down-Counting Timer with Repeat-Count Event Thinning

This block is a down-counting timer that raises fewer events than it would otherwise. A main counter counts down from a programmed reload value. When it reaches zero, it reloads on the next clock edge. A second counter, the repeat counter, advances on every reload. It wraps back to zero after a programmed number of reloads, and each wrap produces a repeat-wrap event.

The zero, reload and match events are passed on only while the repeat counter reads zero. The other reloads stay silent, so a slow interrupt rate can be derived from a fast timer period.

Every event is a one-cycle pulse. Each event also sets a sticky status flag, which software clears by writing a one to that flag's position. A single interrupt line combines the flags with a per-event enable mask.

Top module: `rep_timer`

## Requirements
- R1: While running, `cnt_o` falls by one per clock. In the cycle after `cnt_o` reads 0, it holds the value of `cfg_load`.
- R2: While `cfg_en` is low, the timer is stopped. In that state `rep_o` is 0, `cnt_o` tracks `cfg_load`, and no event pulses. On the first edge with `cfg_en` high, counting starts from `cfg_load`, and no reload event is raised for that start.
- R3: On each reload, the repeat count becomes its old value plus one. It becomes 0 instead when that sum is at least `cfg_rep`, and in that case `ev_repz` pulses in the cycle where `cnt_o` is 0. A setting of 0 or 1 therefore gives a wrap on every reload.
- R4: `ev_zero` pulses in each running cycle where `cnt_o` is 0 and `rep_o` is 0.
- R5: `ev_load` pulses in the cycle right after a reload, but only if `rep_o` is 0 in that cycle.
- R6: `ev_cmp` pulses in each running cycle where `cnt_o` equals `cfg_cmp` and `rep_o` is 0. With `cfg_cmp` at 0, it fires in the same cycle as `ev_zero`.
- R7: The status flags sit in `status` as follows: bit 0 is zero, bit 1 is reload, bit 2 is match, and bit 3 is repeat-wrap. Each flag sets on the edge after its event. A flag clears when `clr_we` is high and `clr_data` has a 1 in its position. If a set and a clear land on the same edge, the set wins.
- R8: `irq` is high exactly when some bit of `status` AND `cfg_ien` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Run enable |
| cfg_load | input | CW | Reload value |
| cfg_cmp | input | CW | Match value |
| cfg_rep | input | RW | Reloads per repeat wrap |
| cfg_ien | input | 4 | Interrupt enable per status flag |
| clr_we | input | 1 | Status clear strobe |
| clr_data | input | 4 | Flags to clear, one per bit |
| ev_zero | output | 1 | Zero event pulse |
| ev_load | output | 1 | Reload event pulse |
| ev_cmp | output | 1 | Match event pulse |
| ev_repz | output | 1 | Repeat-wrap event pulse |
| status | output | 4 | Sticky event flags |
| irq | output | 1 | Interrupt request |
| cnt_o | output | CW | Main counter value |
| rep_o | output | RW | Repeat counter value |

## Verification
Two pairs of functions can fall into the same cycle.

The first pair is zero and match. Programming a match value of 0 makes both events occur at the counter's floor. The scoreboard expects `ev_zero` and `ev_cmp` together, or neither when the repeat count masks them.

The second pair is a status flag being set and a software clear of that same flag. The bench drives the clear strobe on bit 0 for several consecutive cycles while zero events keep firing. It then expects the flag to survive on every edge where an event lands, and to drop on the edges where none does.

// File: rtl/rep_timer.sv
module rep_timer #(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [CW-1:0] cfg_load,
  input  logic [CW-1:0] cfg_cmp,
  input  logic [RW-1:0] cfg_rep,
  input  logic [3:0]    cfg_ien,
  input  logic          clr_we,
  input  logic [3:0]    clr_data,
  output logic          ev_zero,
  output logic          ev_load,
  output logic          ev_cmp,
  output logic          ev_repz,
  output logic [3:0]    status,
  output logic          irq,
  output logic [CW-1:0] cnt_o,
  output logic [RW-1:0] rep_o
);

  logic          run_q, ldf_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] rep_q;
  logic [3:0]    st_q;

  wire [RW:0] rep_inc = {1'b0, rep_q} + 1'b1;
  wire        wrap    = rep_inc >= {1'b0, cfg_rep};
  wire        floor   = run_q && (cnt_q == '0);
  wire        open_q  = (rep_q == '0);

  assign ev_zero = floor && open_q;
  assign ev_cmp  = run_q && (cnt_q == cfg_cmp) && open_q;
  assign ev_load = ldf_q && open_q;
  assign ev_repz = floor && wrap;

  wire [3:0] evs = {ev_repz, ev_cmp, ev_load, ev_zero};
  wire [3:0] clr = clr_we ? clr_data : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ldf_q <= 1'b0;
      cnt_q <= '0;
      rep_q <= '0;
    end else if (!cfg_en || !run_q) begin
      run_q <= cfg_en;
      ldf_q <= 1'b0;
      cnt_q <= cfg_load;
      rep_q <= '0;
    end else if (cnt_q == '0) begin
      ldf_q <= 1'b1;
      cnt_q <= cfg_load;
      rep_q <= wrap ? '0 : rep_inc[RW-1:0];
    end else begin
      ldf_q <= 1'b0;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr) | evs;
  end

  assign status = st_q;
  assign irq    = |(st_q & cfg_ien);
  assign cnt_o  = cnt_q;
  assign rep_o  = rep_q;

  p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cfg_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cfg_en && cnt_q == '0) |=> (cnt_q == $past(cfg_load)));

  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (rep_q == '0 && !ev_zero && !ev_load && !ev_cmp && !ev_repz));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_repz |=> (rep_q == '0));

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_q != '0) |-> (!ev_zero && !ev_cmp && !ev_load));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> status[0]);

endmodule

// File: tb/rep_timer_tb.sv
module rep_timer_tb_top;
  localparam int CW = 16;
  localparam int RW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0, clr_we = 1'b0;
  logic [CW-1:0] cfg_load = '0, cfg_cmp = '0;
  logic [RW-1:0] cfg_rep = '0;
  logic [3:0] cfg_ien = '0, clr_data = '0;
  logic ev_zero, ev_load, ev_cmp, ev_repz, irq;
  logic [3:0] status;
  logic [CW-1:0] cnt_o;
  logic [RW-1:0] rep_o;

  int checks = 0, fails = 0;

  rep_timer #(.CW(CW), .RW(RW)) dut_i (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [3:0]    ev;
    logic [CW-1:0] cnt;
    logic [RW-1:0] rep;
    logic [3:0]    st;
    logic          irq;
  } exp_t;

  exp_t q[$];

  logic          m_run = 0, m_ld = 0;
  logic [CW-1:0] m_cnt = '0;
  logic [RW-1:0] m_rep = '0;
  logic [3:0]    m_st = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply inputs for one cycle, push expected outputs, advance model.
  task automatic step(input logic en, input logic [3:0] clrv, input logic cw);
    exp_t e;
    int nxt;
    cfg_en = en; clr_we = cw; clr_data = clrv;
    nxt = int'(m_rep) + 1;
    if (nxt >= int'(cfg_rep)) nxt = 0;
    e.ev[0] = m_run && m_cnt == 0 && m_rep == 0;
    e.ev[1] = m_ld && m_rep == 0;
    e.ev[2] = m_run && m_cnt == cfg_cmp && m_rep == 0;
    e.ev[3] = m_run && m_cnt == 0 && nxt == 0;
    e.cnt = m_cnt; e.rep = m_rep; e.st = m_st;
    e.irq = |(m_st & cfg_ien);
    q.push_back(e);
    m_st = (m_st & ~(cw ? clrv : 4'b0)) | e.ev;
    if (!en || !m_run) begin
      m_run = en; m_cnt = cfg_load; m_rep = '0; m_ld = 0;
    end else if (m_cnt == 0) begin
      m_cnt = cfg_load; m_rep = RW'(nxt); m_ld = 1;
    end else begin
      m_cnt = m_cnt - 1'b1; m_ld = 0;
    end
    @(posedge clk); #1;
  endtask

  // Monitor: compare DUT outputs against queued expectations.
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1 count", 32'(cnt_o), 32'(e.cnt));
      chk("R2 repeat value", 32'(rep_o), 32'(e.rep));
      chk("R3 repeat wrap", 32'(ev_repz), 32'(e.ev[3]));
      chk("R4 zero", 32'(ev_zero), 32'(e.ev[0]));
      chk("R5 reload", 32'(ev_load), 32'(e.ev[1]));
      chk("R6 match", 32'(ev_cmp), 32'(e.ev[2]));
      chk("R7 status", 32'(status), 32'(e.st));
      chk("R8 irq", 32'(irq), 32'(e.irq));
    end
  end

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset status", 32'(status), 32'h0);
    chk("R8 reset irq", 32'(irq), 32'h0);
    chk("R2 reset events", 32'({ev_zero, ev_load, ev_cmp, ev_repz}), 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Scenario A: four reloads per wrap, match at 1, interrupt on wrap flag.
    cfg_load = 3; cfg_cmp = 1; cfg_rep = 4; cfg_ien = 4'b1000;
    repeat (4) step(1'b0, 4'h0, 1'b0);
    repeat (44) step(1'b1, 4'h0, 1'b0);
    step(1'b1, 4'hF, 1'b1);

    // Stop: repeat counter forced to zero, events silent.
    repeat (5) step(1'b0, 4'h0, 1'b0);

    // Scenario B: no thinning, match at zero coincides with zero event.
    cfg_load = 2; cfg_cmp = 0; cfg_rep = 0; cfg_ien = 4'b0001;
    repeat (15) step(1'b1, 4'h0, 1'b0);
    repeat (8) step(1'b1, 4'h1, 1'b1);
    repeat (3) step(1'b1, 4'h0, 1'b0);

    // Scenario C: reload value zero, wrap every second reload.
    step(1'b0, 4'hF, 1'b1);
    cfg_load = 0; cfg_cmp = 5; cfg_rep = 2; cfg_ien = 4'b0110;
    repeat (12) step(1'b1, 4'h0, 1'b0);
    repeat (3) step(1'b1, 4'h2, 1'b1);

    // Scenario D: larger period, wrap of 3, clear while idle.
    step(1'b0, 4'h0, 1'b0);
    cfg_load = 5; cfg_cmp = 3; cfg_rep = 3; cfg_ien = 4'b1111;
    repeat (60) step(1'b1, 4'h0, 1'b0);
    repeat (3) step(1'b0, 4'hF, 1'b1);

    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule